// File: doc/BRIEF.md
# Lockable Watchdog Supervisor with Reset-Cause Record

The block supervises software progress by counting carry pulses from an external free-running time-base prescaler. Four carry taps of increasing period arrive on `carry_i`. Software arms the watchdog with its first kick, and the two interval bits written with that kick choose the tap. Each later kick clears the two-bit watchdog counter. If the counter is allowed to advance three times without a kick, the block issues a one-cycle system reset request on `wdt_req_o` and returns to the stopped state. Software has no way to disarm it.

The counter is cleared on any reset and when the system enters a low-power mode. In timer mode it is also held at zero for as long as the mode lasts. A four-bit cause record shows which reset happened last. Reading it clears it. Only carry pulses count, so a prescaler clear that delays a carry stretches the timeout by the same amount.

Top module: `wdog_sup`

## Requirements
- R1: After any reset the watchdog is stopped, and carry pulses on any tap produce no request until software writes 0 to the kick bit (`wr_en_i`=1, `wr_kick_i`=0).
- R2: The arming kick latches `wr_ivl_i` as a tap index (0 is the shortest period, 3 the longest). Only pulses on `carry_i[index]` advance the counter.
- R3: A kick while the watchdog is running clears the counter to zero. Its `wr_ivl_i` value is ignored and the latched tap is kept.
- R4: On the third counted carry since the last clear, `wdt_req_o` is high for exactly one cycle, starting the cycle after that carry is sampled. The watchdog is then stopped.
- R5: Writing 1 to the kick bit has no effect. A running watchdog keeps counting.
- R6: When a kick and a counted carry fall in the same cycle, the kick wins. Even on the third carry, no request is issued and the counter restarts from zero.
- R7: When `mode_i` (0 run, 1 sleep, 2 stop, 3 timer) changes to a nonzero value, the counter is cleared. While `mode_i` is 3, carries are not counted.
- R8: `cause_o` bit 0 is power-on, bit 1 is watchdog, bit 2 is external pin and bit 3 is software reset. A watchdog request sets bit 1 and clears the other bits.
- R9: A pulse on `ext_rst_i` or `sw_rst_i` stops the watchdog, clears the counter and leaves only its own cause bit (2 or 3) set.
- R10: Power-on reset (`por_ni` low, asynchronous) stops the watchdog and leaves `cause_o` = 4'b0001.
- R11: `rd_en_i` clears all cause bits on the next cycle. A reset event in the same cycle takes priority and its bit is kept.
- R12: The timeout is measured in counted carries, not clock cycles. Irregularly spaced carries delay the request until the third one arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_ni | input | 1 | Asynchronous power-on reset, active low |
| carry_i | input | 4 | Prescaler carry pulses, one per tap |
| mode_i | input | 2 | Power mode: 0 run, 1 sleep, 2 stop, 3 timer |
| wr_en_i | input | 1 | Control register write strobe |
| wr_kick_i | input | 1 | Kick bit value; 0 arms or clears |
| wr_ivl_i | input | 2 | Interval (tap) select written with the kick |
| rd_en_i | input | 1 | Cause register read strobe (clears on read) |
| ext_rst_i | input | 1 | External pin reset event pulse |
| sw_rst_i | input | 1 | Software reset event pulse |
| wdt_req_o | output | 1 | One-cycle system reset request |
| cause_o | output | 4 | Reset cause flags |

## Verification
The critical collision is a kick that arrives in the same cycle as the carry that would cause an overflow. The bench arms the watchdog and lets two carries pass. It then drives the kick and the third carry in the same cycle. The scoreboard expects no request at that point and a request only after three further carries. A second collision is also provoked: a cause read in the same cycle as an external reset. The record is expected to keep the external bit rather than clear it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        MD_RUN   = 2'd0,
        MD_SLEEP = 2'd1,
        MD_STOP  = 2'd2,
        MD_TIMER = 2'd3
    } pwr_mode_e;

    localparam int CAUSE_W   = 4;
    localparam int CZ_POR    = 0;
    localparam int CZ_WDOG   = 1;
    localparam int CZ_EXT    = 2;
    localparam int CZ_SW     = 3;

endpackage

// File: rtl/wdog_tap_sel.sv
module wdog_tap_sel #(
    parameter int NTAP = 4,
    localparam int IW  = $clog2(NTAP)
) (
    input  logic [NTAP-1:0] carry_i,
    input  logic [IW-1:0]   tap_i,
    output logic            tick_o
);

    logic [NTAP-1:0] hit;

    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        assign hit[g] = carry_i[g] && (tap_i == IW'(g));
    end

    assign tick_o = |hit;

endmodule

// File: rtl/wdog_ctr.sv
module wdog_ctr
    import wdog_pkg::*;
#(
    parameter int NTAP = 4,
    parameter int CW   = 2,
    localparam int IW  = $clog2(NTAP),
    localparam logic [CW-1:0] LAST = CW'((1 << CW) - 2)
) (
    input  logic          clk_i,
    input  logic          por_ni,
    input  logic          kick_i,
    input  logic [IW-1:0] ivl_i,
    input  logic          tick_i,
    input  logic [1:0]    mode_i,
    input  logic          rst_ev_i,
    output logic [IW-1:0] tap_o,
    output logic          run_o,
    output logic [CW-1:0] cnt_o,
    output logic          req_next_o,
    output logic          req_o
);

    typedef struct packed {
        logic          run;
        logic [IW-1:0] tap;
        logic [CW-1:0] cnt;
        logic          req;
        pwr_mode_e     mode;
    } ctr_st_t;

    ctr_st_t st_d, st_q;
    pwr_mode_e mode_now;

    assign mode_now = pwr_mode_e'(mode_i);

    always_comb begin
        st_d      = st_q;
        st_d.req  = 1'b0;
        st_d.mode = mode_now;

        if (st_q.run && tick_i && mode_now != MD_TIMER) begin
            if (st_q.cnt == LAST) begin
                st_d.req = 1'b1;
                st_d.run = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        if (mode_now != MD_RUN && mode_now != st_q.mode) begin
            st_d.cnt = '0;
        end
        if (mode_now == MD_TIMER) begin
            st_d.cnt = '0;
        end

        if (kick_i) begin
            if (!st_q.run) begin
                st_d.tap = ivl_i;
            end
            st_d.run = 1'b1;
            st_d.cnt = '0;
            st_d.req = 1'b0;
        end

        if (rst_ev_i) begin
            st_d.run = 1'b0;
            st_d.cnt = '0;
            st_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) begin
            st_q <= '{run: 1'b0, tap: '0, cnt: '0, req: 1'b0, mode: MD_RUN};
        end else begin
            st_q <= st_d;
        end
    end

    assign tap_o      = st_q.tap;
    assign run_o      = st_q.run;
    assign cnt_o      = st_q.cnt;
    assign req_o      = st_q.req;
    assign req_next_o = st_d.req;

endmodule

// File: rtl/wdog_cause.sv
module wdog_cause
    import wdog_pkg::*;
(
    input  logic               clk_i,
    input  logic               por_ni,
    input  logic               wd_ev_i,
    input  logic               ext_ev_i,
    input  logic               sw_ev_i,
    input  logic               rd_en_i,
    output logic [CAUSE_W-1:0] cause_o
);

    typedef struct packed {
        logic [CAUSE_W-1:0] flags;
    } cause_st_t;

    cause_st_t st_d, st_q;
    logic      any_ev;

    assign any_ev = wd_ev_i || ext_ev_i || sw_ev_i;

    always_comb begin
        st_d = st_q;
        if (rd_en_i) begin
            st_d.flags = '0;
        end
        if (any_ev) begin
            st_d.flags          = '0;
            st_d.flags[CZ_WDOG] = wd_ev_i;
            st_d.flags[CZ_EXT]  = ext_ev_i;
            st_d.flags[CZ_SW]   = sw_ev_i;
        end
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) begin
            st_q.flags         <= '0;
            st_q.flags[CZ_POR] <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_o = st_q.flags;

endmodule

// File: rtl/wdog_sup.sv
module wdog_sup
    import wdog_pkg::*;
#(
    parameter int NTAP = 4,
    parameter int CW   = 2,
    localparam int IW  = $clog2(NTAP)
) (
    input  logic               clk_i,
    input  logic               por_ni,
    input  logic [NTAP-1:0]    carry_i,
    input  logic [1:0]         mode_i,
    input  logic               wr_en_i,
    input  logic               wr_kick_i,
    input  logic [IW-1:0]      wr_ivl_i,
    input  logic               rd_en_i,
    input  logic               ext_rst_i,
    input  logic               sw_rst_i,
    output logic               wdt_req_o,
    output logic [CAUSE_W-1:0] cause_o
);

    logic          kick;
    logic          tick;
    logic          req_next;
    logic [IW-1:0] tap_w;
    logic          run_w;
    logic [CW-1:0] cnt_w;

    assign kick = wr_en_i && !wr_kick_i;

    wdog_tap_sel #(.NTAP(NTAP)) u_tap (
        .carry_i (carry_i),
        .tap_i   (tap_w),
        .tick_o  (tick)
    );

    wdog_ctr #(.NTAP(NTAP), .CW(CW)) u_ctr (
        .clk_i      (clk_i),
        .por_ni     (por_ni),
        .kick_i     (kick),
        .ivl_i      (wr_ivl_i),
        .tick_i     (tick),
        .mode_i     (mode_i),
        .rst_ev_i   (ext_rst_i || sw_rst_i),
        .tap_o      (tap_w),
        .run_o      (run_w),
        .cnt_o      (cnt_w),
        .req_next_o (req_next),
        .req_o      (wdt_req_o)
    );

    wdog_cause u_cause (
        .clk_i    (clk_i),
        .por_ni   (por_ni),
        .wd_ev_i  (req_next),
        .ext_ev_i (ext_rst_i),
        .sw_ev_i  (sw_rst_i),
        .rd_en_i  (rd_en_i),
        .cause_o  (cause_o)
    );

endmodule

// File: rtl/wdog_sup_chk.sv
module wdog_sup_chk #(
    parameter int CW = 2
) (
    input logic          clk_i,
    input logic          por_ni,
    input logic          wdt_req_o,
    input logic [3:0]    cause_o,
    input logic          wr_en_i,
    input logic          wr_kick_i,
    input logic          rd_en_i,
    input logic          ext_rst_i,
    input logic          sw_rst_i,
    input logic [1:0]    mode_i,
    input logic          run_w,
    input logic [CW-1:0] cnt_w
);

    // R4
    req_single_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        wdt_req_o |=> !wdt_req_o);

    // R4
    req_stops_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        wdt_req_o |-> !run_w || $past(wr_en_i && !wr_kick_i));

    // R1
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        !run_w |=> !wdt_req_o);

    // R8
    wd_flag_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        wdt_req_o |-> cause_o[1]);

    // R9
    ext_stop_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        ext_rst_i |=> !run_w && cause_o[2] && cnt_w == '0);

    // R9
    sw_stop_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        sw_rst_i |=> !run_w && cause_o[3]);

    // R3
    kick_clr_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        (wr_en_i && !wr_kick_i && !ext_rst_i && !sw_rst_i) |=> run_w && cnt_w == '0 && !wdt_req_o);

    // R7
    timer_hold_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        (mode_i == 2'd3) |=> cnt_w == '0);

    // R11
    rd_clear_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        (rd_en_i && !ext_rst_i && !sw_rst_i && !wdt_req_o) |=> cause_o == 4'b0000 || wdt_req_o);

endmodule

bind wdog_sup wdog_sup_chk #(.CW(CW)) u_chk (
    .clk_i     (clk_i),
    .por_ni    (por_ni),
    .wdt_req_o (wdt_req_o),
    .cause_o   (cause_o),
    .wr_en_i   (wr_en_i),
    .wr_kick_i (wr_kick_i),
    .rd_en_i   (rd_en_i),
    .ext_rst_i (ext_rst_i),
    .sw_rst_i  (sw_rst_i),
    .mode_i    (mode_i),
    .run_w     (run_w),
    .cnt_w     (cnt_w)
);

// File: tb/sim_wdog_sup.sv
module sim_wdog_sup;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic [3:0] carry = '0;
    logic [1:0] mode = '0;
    logic       wr_en = 1'b0;
    logic       wr_kick = 1'b1;
    logic [1:0] wr_ivl = '0;
    logic       rd_en = 1'b0;
    logic       ext_rst = 1'b0;
    logic       sw_rst = 1'b0;
    logic       wdt_req;
    logic [3:0] cause;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    wdog_sup u0 (
        .clk_i     (clk),
        .por_ni    (por_n),
        .carry_i   (carry),
        .mode_i    (mode),
        .wr_en_i   (wr_en),
        .wr_kick_i (wr_kick),
        .wr_ivl_i  (wr_ivl),
        .rd_en_i   (rd_en),
        .ext_rst_i (ext_rst),
        .sw_rst_i  (sw_rst),
        .wdt_req_o (wdt_req),
        .cause_o   (cause)
    );

    // Monitor: every request pulse must match the head of the expectation queue.
    always @(negedge clk) begin
        if (por_n && wdt_req) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R4 unexpected request at cycle %0d (expected none)", cyc);
            end else begin
                int want;
                want = exp_q.pop_front();
                if (want != cyc) begin
                    errors++;
                    $display("FAIL R4 request at cycle %0d, expected cycle %0d", cyc, want);
                end
            end
        end
    end

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", req, act, exp);
        end
    endtask

    // One cycle of stimulus; exp_req pushes the cycle where the request must show.
    task automatic drive(input logic we, input logic kb, input logic [1:0] ivl,
                         input logic [3:0] cy, input logic rd, input logic ex,
                         input logic sw, input bit exp_req);
        @(negedge clk);
        wr_en = we; wr_kick = kb; wr_ivl = ivl; carry = cy;
        rd_en = rd; ext_rst = ex; sw_rst = sw;
        if (exp_req) exp_q.push_back(cyc + 1);
        @(negedge clk);
        wr_en = 1'b0; wr_kick = 1'b1; carry = '0; rd_en = 1'b0;
        ext_rst = 1'b0; sw_rst = 1'b0;
    endtask

    task automatic kick(input logic [1:0] ivl);
        drive(1'b1, 1'b0, ivl, 4'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic pulse(input logic [3:0] cy, input bit exp_req);
        drive(1'b0, 1'b1, 2'd0, cy, 1'b0, 1'b0, 1'b0, exp_req);
    endtask

    task automatic rd();
        drive(1'b0, 1'b1, 2'd0, 4'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired (bench hung)");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(2);
        por_n = 1'b1;
        idle(1);
        // R10 power-on state, R1 no request
        chk("R10 cause after power-on", cause, 4'b0001);
        chk("R1 no request after reset", {3'b0, wdt_req}, 4'b0);
        rd();
        chk("R11 read clears", cause, 4'b0000);

        // R1: unarmed, carries ignored
        for (int i = 0; i < 4; i++) pulse(4'hF, 0);

        // R2: armed with tap 1; tap 0 carries do not count
        kick(2'd1);
        for (int i = 0; i < 4; i++) pulse(4'b0001, 0);
        pulse(4'b0010, 0);
        pulse(4'b0010, 0);
        pulse(4'b0010, 1);
        chk("R8 watchdog cause", cause, 4'b0010);
        // R4: stopped after request
        for (int i = 0; i < 4; i++) pulse(4'hF, 0);
        rd();
        chk("R11 read clears watchdog flag", cause, 4'b0000);

        // R3 and R2: later kick clears, its interval ignored
        kick(2'd0);
        pulse(4'b0001, 0);
        pulse(4'b0001, 0);
        kick(2'd3);
        for (int i = 0; i < 3; i++) pulse(4'b1000, 0);
        pulse(4'b0001, 0);
        pulse(4'b0001, 0);
        pulse(4'b0001, 1);
        chk("R3 timeout after late kick", cause, 4'b0010);

        // R5: writing 1 to kick does nothing
        kick(2'd0);
        pulse(4'b0001, 0);
        drive(1'b1, 1'b1, 2'd2, 4'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        pulse(4'b0001, 0);
        pulse(4'b0001, 1);

        // R6: kick and third carry in one cycle
        kick(2'd0);
        pulse(4'b0001, 0);
        pulse(4'b0001, 0);
        drive(1'b1, 1'b0, 2'd0, 4'b0001, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R6 no request on collision", {3'b0, wdt_req}, 4'b0);
        pulse(4'b0001, 0);
        pulse(4'b0001, 0);
        pulse(4'b0001, 1);

        // R7: sleep entry clears
        kick(2'd0);
        pulse(4'b0001, 0);
        pulse(4'b0001, 0);
        @(negedge clk); mode = 2'd1;
        @(negedge clk); mode = 2'd0;
        pulse(4'b0001, 0);
        pulse(4'b0001, 0);
        pulse(4'b0001, 1);
        // R7: timer mode freezes
        kick(2'd0);
        pulse(4'b0001, 0);
        @(negedge clk); mode = 2'd3;
        for (int i = 0; i < 5; i++) pulse(4'b0001, 0);
        @(negedge clk); mode = 2'd0;
        pulse(4'b0001, 0);
        pulse(4'b0001, 0);
        pulse(4'b0001, 1);

        // R12: irregular carry spacing
        kick(2'd2);
        pulse(4'b0100, 0);
        idle(20);
        pulse(4'b0100, 0);
        idle(50);
        chk("R12 no request before third carry", {3'b0, wdt_req}, 4'b0);
        pulse(4'b0100, 1);

        // R9: external reset stops it
        kick(2'd0);
        pulse(4'b0001, 0);
        drive(1'b0, 1'b1, 2'd0, 4'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R9 external cause", cause, 4'b0100);
        for (int i = 0; i < 4; i++) pulse(4'b0001, 0);
        kick(2'd0);
        drive(1'b0, 1'b1, 2'd0, 4'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R9 software cause", cause, 4'b1000);
        for (int i = 0; i < 4; i++) pulse(4'b0001, 0);
        // R11: read with external event in the same cycle
        drive(1'b0, 1'b1, 2'd0, 4'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R11 event beats read", cause, 4'b0100);

        // R10: power-on mid-run
        kick(2'd0);
        pulse(4'b0001, 0);
        pulse(4'b0001, 0);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        chk("R10 cause after power-on", cause, 4'b0001);
        for (int i = 0; i < 4; i++) pulse(4'b0001, 0);

        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R4 missing requests actual %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule